// File: doc/BRIEF.md
# Synchronous Burst Memory with Selectable Read Timing

This block is a clocked on-chip memory with a burst interface. All commands are sampled on the rising clock edge. A command is built from two active-low address strobes, a burst-advance input, three chip enables and a set of write controls. The processor-side strobe can only start reads. The controller-side strobe starts either a read or a write. Once a burst has started, the low two address bits come from an internal 2-bit beat counter. That counter steps in linear or interleaved order, selected by a pin, and it wraps after four beats.

Three static mode pins set the read path:
- Read data can come straight from the array in the cycle after capture (flow-through), or from an output register one cycle later (pipelined).
- After a deselect, the output drivers turn off either at once (single-cycle deselect) or one clock later (dual-cycle deselect).

The output pads are modelled as a data bus plus a drive flag. An asynchronous output enable can force the flag low at any time. A sleep input stops the block after two clocks and keeps the array contents. When sleep is released, a recovery window follows in which writes are refused.

Top module: `sbs_sram`

## Requirements
- R1: With linear order selected (`ilv_order_i`=0), beat j of a burst that starts at address S reads or writes address {S[hi], (S[1:0]+j) mod 4}. The burst wraps back to S after the fourth beat.
- R2: With interleaved order selected (`ilv_order_i`=1), beat j addresses {S[hi], S[1:0] XOR j}.
- R3: When both strobes are high and a burst is active, `adv_ni` low moves to the next beat. `adv_ni` high repeats the current address.
- R4: Each enable condition is handled as follows:
  - `ce1_ni` high masks `ads_p_ni`.
  - `ce1_ni` high with `ads_c_ni` low is a deselect.
  - `ce2_i` (active high) and `ce3_ni` (active low) are examined only when a strobe starts a cycle. If either is inactive at that point, the cycle is a deselect.
- R5: A cycle started by `ads_p_ni` is a read whatever the write controls are.
- R6: The write controls decide between write and read:
  - `gw_ni` low writes all lanes.
  - Otherwise `bw_ni` low writes exactly the lanes whose `be_ni` bit is low (bit k = bits k*LANE_W upward).
  - `bw_ni` high, or no `be_ni` bit low, makes the cycle a read.
- R7: In pipelined mode (`flow_thru_i`=0), data for a read captured at edge k appears after edge k+1.
- R8: In flow-through mode (`flow_thru_i`=1), data for a read captured at edge k appears after edge k.
- R9: With single-cycle deselect (`dual_desel_i`=0), `drive_o` is low right after the deselect edge. With dual-cycle deselect, the previous read data stays driven for one more cycle.
- R10: `oe_ni` high forces `drive_o` low asynchronously. Reads issued with `oe_ni` high still advance the burst.
- R11: `drive_o` is low in the cycle after any write is captured.
- R12: `sleep_i` high sampled at edge k stops the block from edge k+2 on. While stopped, commands are ignored, `drive_o` is low and the array keeps its contents.
- R13: After sleep ends, WAKE_CYC further edges accept reads and deselects but drop writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_thru_i | input | 1 | 1 = flow-through read, 0 = pipelined |
| ilv_order_i | input | 1 | 1 = interleaved burst order, 0 = linear |
| dual_desel_i | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| addr_i | input | ADDR_W | Word address |
| ads_p_ni | input | 1 | Processor-side address strobe, active low |
| ads_c_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary chip enable, active high |
| ce3_ni | input | 1 | Secondary chip enable, active low |
| gw_ni | input | 1 | Global write, active low |
| bw_ni | input | 1 | Byte-write enable, active low |
| be_ni | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | LANES*LANE_W | Read data (zero when not driving) |
| drive_o | output | 1 | Output drivers on |

## Verification
The bench builds the block with its defaults: four 8-bit lanes, 64 words and a recovery count of 4. With 64 words the whole array can be filled and read back through a scoreboard. Four lanes let a single burst mix partial, global and empty lane masks. Bursts start at word 5 and word 63, whose low bits make the linear and interleaved sequences differ, and word 63 also shows the wrap staying inside its group of four. A recovery count of 4 is short enough that both a dropped write and an honoured read fall inside the window, and an accepted write follows it.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_cmd_dec.sv
`timescale 1ns/1ps
module sbs_cmd_dec
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ads_p_ni,
  input  logic             ads_c_ni,
  input  logic             adv_ni,
  input  logic             ce1_ni,
  input  logic             ce2_i,
  input  logic             ce3_ni,
  input  logic             gw_ni,
  input  logic             bw_ni,
  input  logic [LANES-1:0] be_ni,
  input  logic             act_i,
  input  logic             asleep_i,
  input  logic             recov_i,
  output op_e              op_o,
  output logic             load_o,
  output logic             step_o,
  output logic             act_d_o,
  output logic [LANES-1:0] wmask_o
);
  logic p_go, sec_ok, wr_req;

  assign p_go    = !ads_p_ni && !ce1_ni;
  assign sec_ok  = ce2_i && !ce3_ni;
  assign wmask_o = !gw_ni ? {LANES{1'b1}} : (!bw_ni ? ~be_ni : '0);
  assign wr_req  = |wmask_o;

  always_comb begin
    op_o    = OP_NOP;
    load_o  = 1'b0;
    step_o  = 1'b0;
    act_d_o = act_i;
    if (!asleep_i) begin
      if (p_go) begin
        act_d_o = sec_ok;
        if (sec_ok) begin
          load_o = 1'b1;
          op_o   = OP_RD;
        end
      end else if (!ads_c_ni) begin
        act_d_o = !ce1_ni && sec_ok;
        if (!ce1_ni && sec_ok) begin
          load_o = 1'b1;
          op_o   = wr_req ? OP_WR : OP_RD;
        end
      end else if (act_i) begin
        step_o = !adv_ni;
        op_o   = wr_req ? OP_WR : OP_RD;
      end
      // writes refused while waking up
      if (op_o == OP_WR && recov_i) op_o = OP_NOP;
    end
  end
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_n;
  logic [1:0]      lo0_q, lo0_n, beat_q, beat_n, lo;

  assign hi_n   = load_i ? addr_i[ADDR_W-1:2] : hi_q;
  assign lo0_n  = load_i ? addr_i[1:0] : lo0_q;
  assign beat_n = load_i ? 2'd0 : beat_q + {1'b0, step_i};
  assign lo     = ilv_i ? (lo0_n ^ beat_n) : (lo0_n + beat_n);
  assign eff_o  = {hi_n, lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo0_q  <= '0;
      beat_q <= '0;
    end else begin
      hi_q   <= hi_n;
      lo0_q  <= lo0_n;
      beat_q <= beat_n;
    end
  end
endmodule

// File: rtl/sbs_sleep_ctl.sv
`timescale 1ns/1ps
module sbs_sleep_ctl #(
  parameter int WAKE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic asleep_o,
  output logic recov_o
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= sleep_i;
      s2_q <= s1_q;
      if (s2_q && !s1_q)    cnt_q <= CNT_W'(WAKE_CYC);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign asleep_o = s2_q;
  assign recov_o  = (cnt_q != 0);
endmodule

// File: rtl/sbs_out_stage.sv
`timescale 1ns/1ps
module sbs_out_stage
  import sbs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flow_i,
  input  logic         dual_i,
  input  logic         oe_ni,
  input  logic         asleep_i,
  input  op_e          op_i,
  input  logic [W-1:0] arr_word_i,
  output logic [W-1:0] rdata_o,
  output logic         drive_o
);
  logic         rd1_q, wr1_q, rd2_q, des1, stage_on;
  logic [W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd1_q  <= 1'b0;
      wr1_q  <= 1'b0;
      rd2_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      rd1_q  <= (op_i == OP_RD);
      wr1_q  <= (op_i == OP_WR);
      rd2_q  <= rd1_q;
      dout_q <= arr_word_i;
    end
  end

  assign des1 = !rd1_q && !wr1_q;

  // flow: live word; dual deselect holds last registered word one more cycle
  // pipe: registered word; single deselect cuts it at once
  assign stage_on = flow_i ? (rd1_q || (dual_i && des1 && rd2_q))
                           : (rd2_q && !wr1_q && !(!dual_i && des1));

  assign drive_o = stage_on && !oe_ni && !asleep_i;
  assign rdata_o = !drive_o ? '0 : ((flow_i && rd1_q) ? arr_word_i : dout_q);
endmodule

// File: rtl/sbs_sram.sv
`timescale 1ns/1ps
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 6,
  parameter int WAKE_CYC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flow_thru_i,
  input  logic                    ilv_order_i,
  input  logic                    dual_desel_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    ads_p_ni,
  input  logic                    ads_c_ni,
  input  logic                    adv_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    gw_ni,
  input  logic                    bw_ni,
  input  logic [LANES-1:0]        be_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  op_e               op;
  logic              load, step, act_d, act_q, asleep, recov;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] eff, addr1_q;
  logic [W-1:0]      mem [DEPTH];
  logic [W-1:0]      arr_word;

  sbs_sleep_ctl #(.WAKE_CYC(WAKE_CYC)) u_sleep (
    .clk_i, .rst_ni, .sleep_i,
    .asleep_o(asleep), .recov_o(recov)
  );

  sbs_cmd_dec #(.LANES(LANES)) u_dec (
    .ads_p_ni, .ads_c_ni, .adv_ni, .ce1_ni, .ce2_i, .ce3_ni,
    .gw_ni, .bw_ni, .be_ni,
    .act_i(act_q), .asleep_i(asleep), .recov_i(recov),
    .op_o(op), .load_o(load), .step_o(step), .act_d_o(act_d), .wmask_o(wmask)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i, .rst_ni, .load_i(load), .step_i(step),
    .ilv_i(ilv_order_i), .addr_i, .eff_o(eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      addr1_q <= '0;
    end else begin
      act_q   <= act_d;
      addr1_q <= eff;
    end
  end

  // reset-free array, lane-masked write at capture edge
  always_ff @(posedge clk_i) begin
    if (op == OP_WR) begin
      for (int l = 0; l < LANES; l++) begin
        if (wmask[l]) mem[eff][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arr_word = mem[addr1_q];

  sbs_out_stage #(.W(W)) u_out (
    .clk_i, .rst_ni, .flow_i(flow_thru_i), .dual_i(dual_desel_i),
    .oe_ni, .asleep_i(asleep), .op_i(op), .arr_word_i(arr_word),
    .rdata_o, .drive_o
  );
endmodule

// File: rtl/sbs_sram_chk.sv
`timescale 1ns/1ps
module sbs_sram_chk
  import sbs_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic flow_thru_i,
  input logic dual_desel_i,
  input logic ads_p_ni,
  input logic ads_c_ni,
  input logic ce1_ni,
  input logic ce2_i,
  input logic ce3_ni,
  input logic oe_ni,
  input logic asleep,
  input logic recov,
  input op_e  op,
  input logic drive_o
);
  p_oe_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  p_sleep_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |-> !drive_o);

  p_write_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WR) |=> !drive_o);

  p_scd_cut_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_thru_i && !dual_desel_i && !ads_c_ni && ce1_ni) |=> !drive_o);

  p_recov_nowrite_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recov |-> (op != OP_WR));

  p_proc_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ads_p_ni && !ce1_ni && ce2_i && !ce3_ni && !asleep) |-> (op == OP_RD));
endmodule

bind sbs_sram sbs_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flow_thru_i(flow_thru_i),
  .dual_desel_i(dual_desel_i), .ads_p_ni(ads_p_ni), .ads_c_ni(ads_c_ni),
  .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni), .oe_ni(oe_ni),
  .asleep(asleep), .recov(recov), .op(op), .drive_o(drive_o)
);

// File: tb/sim_sbs_sram.sv
`timescale 1ns/1ps
module sim_sbs_sram;
  localparam int LW = 8;
  localparam int LN = 4;
  localparam int AW = 6;
  localparam int W  = LW * LN;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flow, ilv, dual;
  logic [AW-1:0] addr;
  logic ads_p, ads_c, adv, ce1, ce2, ce3, gw, bw, oe, slp;
  logic [LN-1:0] be;
  logic [W-1:0] wdata, rdata;
  logic drive;

  logic [W-1:0] sb [D];
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sbs_sram #(.LANE_W(LW), .LANES(LN), .ADDR_W(AW), .WAKE_CYC(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flow_thru_i(flow), .ilv_order_i(ilv),
    .dual_desel_i(dual), .addr_i(addr), .ads_p_ni(ads_p), .ads_c_ni(ads_c),
    .adv_ni(adv), .ce1_ni(ce1), .ce2_i(ce2), .ce3_ni(ce3), .gw_ni(gw),
    .bw_ni(bw), .be_ni(be), .wdata_i(wdata), .oe_ni(oe), .sleep_i(slp),
    .rdata_o(rdata), .drive_o(drive)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int bad(input int s, input int j, input bit il);
    return (s & ~3) | (il ? ((s & 3) ^ j) : ((s + j) & 3));
  endfunction

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [LN-1:0] m);
    logic [W-1:0] r = old;
    for (int l = 0; l < LN; l++) if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic set_idle();
    ads_p = 1; ads_c = 1; adv = 1; ce1 = 0; ce2 = 1; ce3 = 0;
    gw = 1; bw = 1; be = '1; oe = 0; addr = '0; wdata = '0;
  endtask

  task automatic desel_cyc();
    set_idle(); ads_c = 0; ce1 = 1; tick();
  endtask

  task automatic wr_single(input int a, input logic [W-1:0] d);
    set_idle(); ads_c = 0; addr = AW'(a); gw = 0; wdata = d; tick();
    sb[a] = d;
  endtask

  task automatic rd_flow(input int a, input string tag);
    set_idle(); ads_c = 0; addr = AW'(a); tick();
    chk({tag, " drive"}, W'(drive), W'(1));
    chk({tag, " data"}, rdata, sb[a]);
  endtask

  task automatic t_fill();
    flow = 1; desel_cyc();
    for (int a = 0; a < D; a++) wr_single(a, 32'hA5C3_0000 ^ (32'h0101_0101 * a) ^ (a << 3));
    desel_cyc();
  endtask

  task automatic t_burst(input int s, input bit il, input bit fl, input bit use_p, input string tag);
    flow = fl; ilv = il; desel_cyc();
    for (int j = 0; j < 4; j++) begin
      set_idle();
      if (j == 0) begin
        if (use_p) ads_p = 0; else ads_c = 0;
        addr = AW'(s);
      end else adv = 0;
      tick();
      if (fl) begin
        chk({tag, " drive"}, W'(drive), W'(1));
        chk({tag, " beat"}, rdata, sb[bad(s, j, il)]);
      end else if (j > 0) begin
        chk({tag, " beat"}, rdata, sb[bad(s, j - 1, il)]);
      end
    end
    if (!fl) begin
      set_idle(); tick();
      chk({tag, " last beat"}, rdata, sb[bad(s, 3, il)]);
    end
    // fifth step wraps to start
    set_idle(); adv = 0; tick();
    if (fl) chk({tag, " wrap"}, rdata, sb[s]);
    set_idle(); tick();
    if (!fl) chk({tag, " wrap"}, rdata, sb[s]);
    desel_cyc(); ilv = 0;
  endtask

  task automatic t_suspend();
    flow = 1; ilv = 0; desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd20; tick();
    set_idle(); adv = 0; tick();
    chk("R3 advance", rdata, sb[21]);
    set_idle(); tick();
    chk("R3 hold 1", rdata, sb[21]);
    set_idle(); tick();
    chk("R3 hold 2", rdata, sb[21]);
    set_idle(); adv = 0; tick();
    chk("R3 resume", rdata, sb[22]);
    desel_cyc();
  endtask

  task automatic t_bytes();
    logic [W-1:0] d [4];
    logic [LN-1:0] m [4];
    flow = 1; ilv = 0; desel_cyc();
    d[0] = 32'h1111_2222; d[1] = 32'h3333_4444; d[2] = 32'h5555_6666; d[3] = 32'h7777_8888;
    m[0] = 4'b0101; m[1] = 4'b1000; m[2] = 4'b1111; m[3] = 4'b0000;
    for (int j = 0; j < 4; j++) begin
      set_idle(); wdata = d[j];
      if (j == 0) begin ads_c = 0; addr = 6'd9; end else adv = 0;
      case (j)
        0: begin bw = 0; be = 4'b1010; end
        1: begin bw = 0; be = 4'b0111; end
        2: begin gw = 0; be = 4'b1111; end
        default: begin bw = 0; be = 4'b1111; end
      endcase
      tick();
      if (j == 3) chk("R6 no lane is read", W'(drive), W'(1));
      else chk("R6 write not driven", W'(drive), W'(0));
      sb[bad(9, j, 0)] = merge(sb[bad(9, j, 0)], d[j], m[j]);
    end
    desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd30; bw = 1; be = '0; wdata = '1; tick();
    chk("R6 bw high is read", W'(drive), W'(1));
    desel_cyc();
    for (int j = 0; j < 4; j++) rd_flow(bad(9, j, 0), "R6 lane mask");
    rd_flow(30, "R6 bw high no write");
    desel_cyc();
  endtask

  task automatic t_proc();
    flow = 1; desel_cyc();
    set_idle(); ads_p = 0; addr = 6'd40; gw = 0; wdata = 32'hDEAD_BEEF; tick();
    chk("R5 proc strobe reads", rdata, sb[40]);
    desel_cyc();
    rd_flow(40, "R5 no write");
    desel_cyc();
  endtask

  task automatic t_enables();
    flow = 1; ilv = 0; desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd32; tick();
    chk("R4 start", rdata, sb[32]);
    set_idle(); ads_p = 0; ce1 = 1; adv = 0; addr = 6'd50; tick();
    chk("R4 proc masked continues", rdata, sb[33]);
    set_idle(); ce2 = 0; adv = 0; tick();
    chk("R4 ce2 ignored on continue", rdata, sb[34]);
    set_idle(); ads_p = 0; ce2 = 0; addr = 6'd44; tick();
    chk("R4 ce2 low deselects", W'(drive), W'(0));
    rd_flow(44, "R4 reselect");
    set_idle(); ads_c = 0; ce1 = 1; addr = 6'd45; tick();
    chk("R4 ce1 high deselects", W'(drive), W'(0));
    set_idle(); ads_c = 0; ce3 = 1; addr = 6'd45; tick();
    chk("R4 ce3 high deselects", W'(drive), W'(0));
    set_idle(); adv = 0; tick();
    chk("R4 stays deselected", W'(drive), W'(0));
    desel_cyc();
  endtask

  task automatic t_desel(input bit fl, input bit dl);
    string tg;
    tg = $sformatf("R9 flow=%0d dual=%0d", fl, dl);
    flow = fl; dual = dl; desel_cyc(); desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd50; tick();
    if (fl) chk({tg, " R8 read"}, rdata, sb[50]);
    else chk({tg, " R7 not yet"}, W'(drive), W'(0));
    desel_cyc();
    if (dl) chk({tg, " held"}, rdata, sb[50]);
    else chk({tg, " cut"}, W'(drive), W'(0));
    desel_cyc();
    chk({tg, " off"}, W'(drive), W'(0));
    dual = 0;
  endtask

  task automatic t_oe();
    flow = 1; ilv = 0; desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd16; oe = 1; tick();
    chk("R10 oe high blocks", W'(drive), W'(0));
    oe = 0; #1;
    chk("R10 oe low async", rdata, sb[16]);
    set_idle(); adv = 0; oe = 1; tick();
    chk("R10 dummy read quiet", W'(drive), W'(0));
    set_idle(); adv = 0; tick();
    chk("R10 dummy read advanced", rdata, sb[18]);
    desel_cyc();
  endtask

  task automatic t_wquiet();
    flow = 0; desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd50; tick();
    set_idle(); ads_c = 0; addr = 6'd51; gw = 0; wdata = 32'h0BAD_F00D; tick();
    sb[51] = 32'h0BAD_F00D;
    chk("R11 write after read quiet", W'(drive), W'(0));
    desel_cyc(); flow = 1; desel_cyc();
    rd_flow(51, "R11 write landed");
    desel_cyc();
  endtask

  task automatic t_sleep();
    flow = 1; desel_cyc();
    set_idle(); ads_c = 0; addr = 6'd3; slp = 1; tick();
    chk("R12 awake first cycle", rdata, sb[3]);
    set_idle(); ads_c = 0; addr = 6'd4; gw = 0; wdata = 32'h4444_AAAA; tick();
    sb[4] = 32'h4444_AAAA;
    chk("R12 outputs off", W'(drive), W'(0));
    for (int i = 0; i < 3; i++) begin
      set_idle(); ads_c = 0; addr = 6'd5; gw = 0; wdata = 32'hBADB_AD00 + i; tick();
      chk("R12 ignored in sleep", W'(drive), W'(0));
    end
    set_idle(); ads_c = 0; addr = 6'd3; slp = 0; tick();
    chk("R12 still asleep", W'(drive), W'(0));
    set_idle(); ads_c = 0; addr = 6'd3; tick();
    chk("R12 read at exit ignored", W'(drive), W'(0));
    set_idle(); ads_c = 0; addr = 6'd5; gw = 0; wdata = 32'h5555_0001; tick();
    rd_flow(4, "R13 read in recovery");
    set_idle(); ads_c = 0; addr = 6'd5; gw = 0; wdata = 32'h5555_0002; tick();
    desel_cyc();
    wr_single(6, 32'h6666_0006);
    desel_cyc();
    rd_flow(5, "R13 write dropped");
    rd_flow(6, "R13 write after recovery");
    rd_flow(3, "R12 contents kept");
    desel_cyc();
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    flow = 1; ilv = 0; dual = 0; slp = 0;
    set_idle();
    repeat (3) tick();
    chk("R9 reset drive off", W'(drive), W'(0));
    rst_ni = 1;
    tick();
    t_fill();
    t_burst(5, 0, 0, 1, "R1 R7 linear pipe");
    t_burst(63, 0, 1, 0, "R1 R8 linear flow");
    t_burst(5, 1, 0, 0, "R2 R7 interleaved pipe");
    t_burst(63, 1, 1, 1, "R2 R8 interleaved flow");
    t_suspend();
    t_bytes();
    t_proc();
    t_enables();
    t_desel(0, 0);
    t_desel(0, 1);
    t_desel(1, 0);
    t_desel(1, 1);
    t_oe();
    t_wquiet();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule